// File: doc/BRIEF.md
# Cascaded LED Driver Frame Loader

This controller sits on the host side of a chain of 16-bit serial-input, latched, constant-current LED sink drivers. It accepts one display frame of `16 × N_DEV` bits over a valid/ready handshake. It shifts the frame out on a data pin and a shift-clock pin, then raises the latch pin so that every driver in the chain copies its shift register to its output latches in one step.

Pin timing is set by parameters given in system-clock cycles, each already rounded up from the driver's nanosecond limits. These cover the data setup before a clock rise, data hold after it, the minimum clock high and low phases, the spacing from the last clock edge to the latch rise, and the latch width. The output-enable pin is active low. The host can blank the display at any time through a request input, and any blanking pulse lasts at least a minimum number of cycles. An optional mode keeps the outputs blanked for the whole load.

Frame bit `16k+15 … 16k` belongs to chain position `k`, where position 0 is the driver wired nearest the controller. The bits for the farthest driver leave first, and each 16-bit word is sent MSB first. The whole frame is therefore shifted out from bit `16·N_DEV−1` down to bit 0.

Top module: `led_chain_loader`

## Requirements
- R1: `frame_ready` is high only while the loader is idle. A frame is taken on a cycle with `frame_valid` and `frame_ready` both high. `frame_ready` is then low from the next cycle through the last cycle of the latch pulse, and `frame_valid`/`frame_data` have no effect on the frame being loaded during that time.
- R2: Each frame produces exactly `16·N_DEV` rising edges of `drv_sclk`. The value on `drv_sdo` at the n-th rise (n counted from 0) is `frame_data[16·N_DEV−1−n]`, so the farthest driver's word goes first, MSB first.
- R3: Within a frame, `drv_sclk` stays high for exactly `max(CLK_HI_CYC, HOLD_CYC)` cycles at each pulse. Before each rise it stays low for at least `max(CLK_LO_CYC, SETUP_CYC)` cycles.
- R4: `drv_sdo` is unchanged for at least `SETUP_CYC` cycles before each `drv_sclk` rise. It never changes while `drv_sclk` is high, and it changes no sooner than `HOLD_CYC` cycles after a rise.
- R5: `drv_lat` rises exactly `LATCH_GAP_CYC` cycles after the last falling edge of `drv_sclk` in a frame. It stays high for exactly `LATCH_W_CYC` cycles, and `drv_sclk` is low throughout.
- R6: While `blank_req` is high, `drv_oe_n` is high from the following cycle onward.
- R7: Every high pulse on `drv_oe_n` lasts at least `BLANK_MIN_CYC` cycles. A one-cycle `blank_req` gives exactly `BLANK_MIN_CYC` cycles. A request longer than the minimum ends the pulse one cycle after `blank_req` falls.
- R8: With `blank_load_mode` high and held, `drv_oe_n` is high at every `drv_sclk` rise and every `drv_lat` cycle of a load. With it low and `blank_req` low, `drv_oe_n` stays low during a load.
- R9: During and right after reset: `drv_sclk`=0, `drv_lat`=0, `drv_oe_n`=0, `drv_sdo`=0, `frame_ready`=1.
- R10: `frame_ready` is high in the cycle right after the last latch cycle, so a held `frame_valid` starts the next frame with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_valid | input | 1 | Frame offered |
| frame_data | input | 16·N_DEV | Frame contents, chain position k at bits 16k+15..16k |
| blank_load_mode | input | 1 | Blank the outputs for the duration of each load |
| blank_req | input | 1 | Host blanking request |
| frame_ready | output | 1 | Loader idle, frame can be taken |
| drv_sdo | output | 1 | Serial data to the first driver |
| drv_sclk | output | 1 | Shift clock, drivers sample on rise |
| drv_lat | output | 1 | Latch enable, active high |
| drv_oe_n | output | 1 | Output enable, active low (high blanks) |

## Verification
Two events can fall in the same cycle. One is the end of a load, where the latch pulse finishes and the load-time blanking is released. The other is either a fresh host blanking request or the acceptance of the next frame. The bench raises `blank_req` while `drv_lat` is high in blank-during-load mode. It also holds `frame_valid` high across the end of a load, and offers frames shorter than the blanking minimum, so that the minimum-width extension overlaps both. In each case the output-enable pulse width, the latch width, the readiness in the first idle cycle and the bit order of the next frame are all judged against values the bench computes from the requirements.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;

  typedef enum logic [2:0] {
    LD_IDLE,
    LD_LOW,
    LD_HIGH,
    LD_GAP,
    LD_LATCH
  } ld_state_e;

  function automatic int unsigned cyc_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/led_load_seq.sv
module led_load_seq
  import led_drv_pkg::*;
#(
  parameter int unsigned TOTAL_BITS = 32,
  parameter int unsigned L_CYC      = 3,
  parameter int unsigned H_CYC      = 3,
  parameter int unsigned GAP_CYC    = 5,
  parameter int unsigned LAT_CYC    = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [TOTAL_BITS-1:0] in_data,
  output logic                  in_ready,
  output logic                  accept,
  output logic                  busy,
  output logic                  sclk,
  output logic                  sdo,
  output logic                  lat
);

  localparam int unsigned MAXC  = cyc_max(cyc_max(L_CYC, H_CYC), cyc_max(GAP_CYC, LAT_CYC));
  localparam int unsigned CNT_W = $clog2(MAXC + 1);
  localparam int unsigned BIT_W = $clog2(TOTAL_BITS);

  ld_state_e             st_q, st_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [BIT_W-1:0]      bit_q, bit_d;
  logic [TOTAL_BITS-1:0] sh_q, sh_d;
  logic                  sh_en;
  logic                  phase_end;

  assign in_ready = (st_q == LD_IDLE);
  assign accept   = in_valid & in_ready;
  assign busy     = ~in_ready;
  assign sclk     = (st_q == LD_HIGH);
  assign lat      = (st_q == LD_LATCH);
  assign sdo      = sh_q[TOTAL_BITS-1];

  // next-state process
  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    bit_d     = bit_q;
    sh_d      = sh_q;
    sh_en     = 1'b0;
    phase_end = 1'b0;
    unique case (st_q)
      LD_IDLE: begin
        cnt_d = '0;
        if (accept) begin
          st_d  = LD_LOW;
          bit_d = '0;
          sh_en = 1'b1;
          sh_d  = in_data;
        end
      end
      LD_LOW: begin
        phase_end = (cnt_q == CNT_W'(L_CYC - 1));
        if (phase_end) st_d = LD_HIGH;
      end
      LD_HIGH: begin
        phase_end = (cnt_q == CNT_W'(H_CYC - 1));
        if (phase_end) begin
          if (bit_q == BIT_W'(TOTAL_BITS - 1)) begin
            st_d = LD_GAP;
          end else begin
            st_d  = LD_LOW;
            bit_d = bit_q + 1'b1;
            sh_en = 1'b1;
            sh_d  = {sh_q[TOTAL_BITS-2:0], 1'b0};
          end
        end
      end
      LD_GAP: begin
        phase_end = (cnt_q == CNT_W'(GAP_CYC - 1));
        if (phase_end) st_d = LD_LATCH;
      end
      LD_LATCH: begin
        phase_end = (cnt_q == CNT_W'(LAT_CYC - 1));
        if (phase_end) st_d = LD_IDLE;
      end
      default: st_d = LD_IDLE;
    endcase
    if (st_q != LD_IDLE) cnt_d = phase_end ? '0 : cnt_q + 1'b1;
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LD_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      bit_q <= bit_d;
      if (sh_en) sh_q <= sh_d;
    end
  end

endmodule

// File: rtl/led_blank_ctrl.sv
module led_blank_ctrl #(
  parameter int unsigned BLANK_MIN = 225
) (
  input  logic clk,
  input  logic rst_n,
  input  logic blank_req,
  input  logic load_blank_en,
  input  logic load_active,
  output logic oe_n
);

  localparam int unsigned BW = $clog2(BLANK_MIN + 1);
  localparam logic [BW-1:0] MIN_LAST = BW'(BLANK_MIN - 1);

  logic          blank_q, blank_d;
  logic [BW-1:0] run_q, run_d;
  logic          want;

  assign want = blank_req | (load_blank_en & load_active);
  assign oe_n = blank_q;

  // next-state process
  always_comb begin
    blank_d = want | (blank_q & (run_q != MIN_LAST));
    if (!blank_q)                run_d = '0;
    else if (run_q != MIN_LAST)  run_d = run_q + 1'b1;
    else                         run_d = run_q;
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q <= 1'b0;
      run_q   <= '0;
    end else begin
      blank_q <= blank_d;
      run_q   <= run_d;
    end
  end

endmodule

// File: rtl/led_chain_loader.sv
module led_chain_loader
  import led_drv_pkg::*;
#(
  parameter int unsigned N_DEV         = 2,
  parameter int unsigned DEV_BITS      = 16,
  parameter int unsigned SETUP_CYC     = 3,
  parameter int unsigned HOLD_CYC      = 1,
  parameter int unsigned CLK_HI_CYC    = 3,
  parameter int unsigned CLK_LO_CYC    = 3,
  parameter int unsigned LATCH_GAP_CYC = 5,
  parameter int unsigned LATCH_W_CYC   = 5,
  parameter int unsigned BLANK_MIN_CYC = 225
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frame_valid,
  input  logic [N_DEV*DEV_BITS-1:0]   frame_data,
  input  logic                        blank_load_mode,
  input  logic                        blank_req,
  output logic                        frame_ready,
  output logic                        drv_sdo,
  output logic                        drv_sclk,
  output logic                        drv_lat,
  output logic                        drv_oe_n
);

  localparam int unsigned TOTAL_BITS = N_DEV * DEV_BITS;
  localparam int unsigned L_CYC      = cyc_max(CLK_LO_CYC, SETUP_CYC);
  localparam int unsigned H_CYC      = cyc_max(CLK_HI_CYC, HOLD_CYC);

  logic [1:0] rst_pipe;
  logic       rst_int_n;
  logic       accept;
  logic       busy;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  led_load_seq #(
    .TOTAL_BITS(TOTAL_BITS),
    .L_CYC     (L_CYC),
    .H_CYC     (H_CYC),
    .GAP_CYC   (LATCH_GAP_CYC),
    .LAT_CYC   (LATCH_W_CYC)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .in_valid(frame_valid),
    .in_data (frame_data),
    .in_ready(frame_ready),
    .accept  (accept),
    .busy    (busy),
    .sclk    (drv_sclk),
    .sdo     (drv_sdo),
    .lat     (drv_lat)
  );

  led_blank_ctrl #(
    .BLANK_MIN(BLANK_MIN_CYC)
  ) u_blank (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .blank_req    (blank_req),
    .load_blank_en(blank_load_mode),
    .load_active  (busy | accept),
    .oe_n         (drv_oe_n)
  );

endmodule

// File: rtl/led_chain_loader_chk.sv
module led_chain_loader_chk #(
  parameter int unsigned H_CYC     = 3,
  parameter int unsigned BLANK_MIN = 225
) (
  input logic clk,
  input logic rst_n,
  input logic frame_valid,
  input logic blank_load_mode,
  input logic frame_ready,
  input logic drv_sdo,
  input logic drv_sclk,
  input logic drv_lat,
  input logic drv_oe_n
);

  logic [15:0] hi_run;
  logic [15:0] oe_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      oe_run <= '0;
    end else begin
      hi_run <= drv_sclk ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1) : '0;
      oe_run <= drv_oe_n ? ((oe_run == 16'hFFFF) ? oe_run : oe_run + 1'b1) : '0;
    end
  end

  assert_ready_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && frame_ready) |=> !frame_ready);

  assert_not_ready_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    drv_lat |-> !frame_ready);

  assert_shift_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_sclk) |-> !frame_ready);

  assert_high_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_sclk) |-> (hi_run == 16'(H_CYC)));

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_sclk && $past(drv_sclk)) |-> $stable(drv_sdo));

  assert_latch_clk_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_lat && drv_sclk));

  assert_blank_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_oe_n) |-> (oe_run >= 16'(BLANK_MIN)));

  assert_load_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(blank_load_mode) && blank_load_mode && (drv_sclk || drv_lat)) |-> drv_oe_n);

endmodule

bind led_chain_loader led_chain_loader_chk #(
  .H_CYC    (H_CYC),
  .BLANK_MIN(BLANK_MIN_CYC)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .frame_valid    (frame_valid),
  .blank_load_mode(blank_load_mode),
  .frame_ready    (frame_ready),
  .drv_sdo        (drv_sdo),
  .drv_sclk       (drv_sclk),
  .drv_lat        (drv_lat),
  .drv_oe_n       (drv_oe_n)
);

// File: tb/led_chain_loader_tb.sv
module led_chain_loader_tb;

  localparam int unsigned N_DEV     = 2;
  localparam int unsigned TOTAL     = N_DEV * 16;
  localparam int unsigned SETUP_CYC = 3;
  localparam int unsigned HOLD_CYC  = 1;
  localparam int unsigned L_CYC     = 3;
  localparam int unsigned H_CYC     = 3;
  localparam int unsigned GAP_CYC   = 5;
  localparam int unsigned LAT_CYC   = 5;
  localparam int unsigned BLANK_MIN = 225;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             frame_valid;
  logic [TOTAL-1:0] frame_data;
  logic             blank_load_mode;
  logic             blank_req;
  logic             frame_ready;
  logic             drv_sdo, drv_sclk, drv_lat, drv_oe_n;

  always #10 clk = ~clk;

  led_chain_loader #(.N_DEV(N_DEV)) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_valid    (frame_valid),
    .frame_data     (frame_data),
    .blank_load_mode(blank_load_mode),
    .blank_req      (blank_req),
    .frame_ready    (frame_ready),
    .drv_sdo        (drv_sdo),
    .drv_sclk       (drv_sclk),
    .drv_lat        (drv_lat),
    .drv_oe_n       (drv_oe_n)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [TOTAL-1:0] exp_q[$];
  bit mon_on    = 1'b0;
  bit mode_exp  = 1'b0;
  bit quiet_exp = 1'b0;
  bit done      = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // expected shift order: the n-th bit out is frame[TOTAL-1-n]
  function automatic logic exp_bit(input logic [TOTAL-1:0] f, input int n);
    return f[TOTAL-1-n];
  endfunction

  function automatic logic [TOTAL-1:0] rand_frame();
    logic [TOTAL-1:0] f;
    for (int i = 0; i < TOTAL; i += 32) f = (f << 32) | TOTAL'($urandom);
    return f;
  endfunction

  // pin monitor
  logic p_sclk, p_sdo, p_lat, p_oe;
  int lo_run, hi_run, lat_run, oe_run, sdo_run, rise_age, nbits, cycles;
  logic [TOTAL-1:0] cap, cur;
  bit bits_ok;

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_up();
    end
    if (mon_on) begin
      if (drv_sclk && !p_sclk) begin
        chk(lo_run >= int'(L_CYC), "R3 low phase", lo_run, L_CYC);
        chk(((drv_sdo == p_sdo) ? sdo_run : 0) >= int'(SETUP_CYC), "R4 setup", sdo_run, SETUP_CYC);
        chk(!frame_ready, "R1 ready low while shifting", frame_ready, 0);
        if (mode_exp)  chk(drv_oe_n,  "R8 blanked at shift", drv_oe_n, 1);
        if (quiet_exp) chk(!drv_oe_n, "R8 not blanked at shift", drv_oe_n, 0);
        cap = {cap[TOTAL-2:0], drv_sdo};
        nbits++;
      end
      if (!drv_sclk && p_sclk)
        chk(hi_run == int'(H_CYC), "R3 high phase", hi_run, H_CYC);
      if (drv_sdo != p_sdo)
        chk(!drv_sclk && rise_age >= int'(HOLD_CYC), "R4 data change", rise_age, HOLD_CYC);
      if (drv_lat && !p_lat) begin
        chk(lo_run == int'(GAP_CYC), "R5 latch gap", lo_run, GAP_CYC);
        chk(nbits == int'(TOTAL), "R2 bit count", nbits, TOTAL);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 unexpected latch", 1, 0);
        end else begin
          cur = exp_q.pop_front();
          bits_ok = 1'b1;
          for (int n = 0; n < int'(TOTAL); n++)
            if (cap[TOTAL-1-n] != exp_bit(cur, n)) bits_ok = 1'b0;
          chk(bits_ok, "R2 shifted frame", cap, cur);
        end
        nbits = 0;
      end
      if (drv_lat) begin
        chk(!frame_ready, "R1 ready low in latch", frame_ready, 0);
        chk(!drv_sclk, "R5 clock low in latch", drv_sclk, 0);
        if (mode_exp) chk(drv_oe_n, "R8 blanked at latch", drv_oe_n, 1);
      end
      if (!drv_lat && p_lat) begin
        chk(lat_run == int'(LAT_CYC), "R5 latch width", lat_run, LAT_CYC);
        chk(frame_ready, "R10 ready after latch", frame_ready, 1);
      end
      if (!drv_oe_n && p_oe)
        chk(oe_run >= int'(BLANK_MIN), "R7 blank width", oe_run, BLANK_MIN);
    end
    rise_age = (drv_sclk && !p_sclk) ? 1 : rise_age + 1;
    lo_run   = drv_sclk ? 0 : lo_run + 1;
    hi_run   = drv_sclk ? hi_run + 1 : 0;
    lat_run  = drv_lat  ? lat_run + 1 : 0;
    oe_run   = drv_oe_n ? oe_run + 1 : 0;
    sdo_run  = (drv_sdo == p_sdo) ? sdo_run + 1 : 1;
    p_sclk = drv_sclk; p_sdo = drv_sdo; p_lat = drv_lat; p_oe = drv_oe_n;
  end

  task automatic send(input logic [TOTAL-1:0] f);
    while (!frame_ready) @(negedge clk);
    frame_data  = f;
    frame_valid = 1'b1;
    @(posedge clk); #1;
    exp_q.push_back(f);
    frame_valid = 1'b0;
    frame_data  = rand_frame();
    @(negedge clk);
    chk(!frame_ready, "R1 ready drops after accept", frame_ready, 0);
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0 || !frame_ready) @(negedge clk);
  endtask

  task automatic wait_unblanked();
    while (drv_oe_n) @(negedge clk);
  endtask

  initial begin
    int w;
    logic [TOTAL-1:0] f;
    void'($urandom(32'd2718));
    rst_n = 1'b0; frame_valid = 1'b0; frame_data = '0;
    blank_load_mode = 1'b0; blank_req = 1'b0;
    p_sclk = 0; p_sdo = 0; p_lat = 0; p_oe = 0;
    lo_run = 0; hi_run = 0; lat_run = 0; oe_run = 0; sdo_run = 0;
    rise_age = 1000; nbits = 0; cycles = 0; cap = '0;
    repeat (3) @(negedge clk);
    chk(!drv_sclk && !drv_lat && !drv_oe_n && !drv_sdo && frame_ready, "R9 in reset",
        {drv_sclk, drv_lat, drv_oe_n, drv_sdo, frame_ready}, 5'b00001);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!drv_sclk && !drv_lat && !drv_oe_n && !drv_sdo && frame_ready, "R9 after release",
        {drv_sclk, drv_lat, drv_oe_n, drv_sdo, frame_ready}, 5'b00001);
    mon_on = 1'b1;

    // R2 R8: plain load, no blanking expected
    quiet_exp = 1'b1;
    send(32'hA5C3_0F71);
    send({1'b1, {(TOTAL-1){1'b0}}});
    send({{(TOTAL-1){1'b0}}, 1'b1});
    wait_idle();
    chk(!drv_oe_n, "R8 no blank in quiet mode", drv_oe_n, 0);
    quiet_exp = 1'b0;

    // R1: valid held with other data while busy must be ignored
    send(32'h1234_FEDC);
    frame_data = ~32'h1234_FEDC; frame_valid = 1'b1;
    repeat (50) @(negedge clk);
    chk(!frame_ready, "R1 still busy", frame_ready, 0);
    frame_valid = 1'b0;
    wait_idle();

    // R10: valid held across end of load
    send('1);
    frame_data = '0; frame_valid = 1'b1;
    while (!frame_ready) @(negedge clk);
    @(posedge clk); #1;
    exp_q.push_back('0);
    frame_valid = 1'b0;
    @(negedge clk);
    chk(!frame_ready, "R10 taken in first idle cycle", frame_ready, 0);
    wait_idle();

    // R8 R7: blank during load, load shorter than the blanking minimum
    blank_load_mode = 1'b1; mode_exp = 1'b1;
    send(rand_frame());
    wait_idle();
    // collision: host request during latch in blank-during-load mode
    send(rand_frame());
    while (!drv_lat) @(negedge clk);
    blank_req = 1'b1; @(negedge clk); blank_req = 1'b0;
    wait_idle();
    wait_unblanked();
    blank_load_mode = 1'b0; mode_exp = 1'b0;

    // R6 R7: single-cycle request
    repeat (4) @(negedge clk);
    blank_req = 1'b1; @(negedge clk); blank_req = 1'b0;
    chk(drv_oe_n, "R6 blank follows request", drv_oe_n, 1);
    w = 0;
    while (drv_oe_n) begin w++; @(negedge clk); end
    chk(w == int'(BLANK_MIN), "R7 minimum pulse exact", w, BLANK_MIN);

    // R6 R7: long request
    blank_req = 1'b1;
    @(negedge clk);
    w = 0;
    for (int i = 0; i < 300; i++) begin
      if (!drv_oe_n) w++;
      @(negedge clk);
    end
    chk(w == 0, "R6 held for long request", w, 0);
    blank_req = 1'b0;
    @(negedge clk);
    chk(!drv_oe_n, "R7 release after long request", drv_oe_n, 0);

    // random traffic
    for (int it = 0; it < 40; it++) begin
      if ($urandom_range(0, 3) == 0) begin
        wait_idle();
        blank_load_mode = 1'($urandom_range(0, 1));
        mode_exp = blank_load_mode;
      end
      if ($urandom_range(0, 4) == 0) begin
        blank_req = 1'b1;
        repeat ($urandom_range(1, 30)) @(negedge clk);
        blank_req = 1'b0;
      end
      f = rand_frame();
      send(f);
    end
    wait_idle();
    wait_unblanked();
    chk(exp_q.size() == 0, "R2 all frames latched", exp_q.size(), 0);
    repeat (5) @(negedge clk);
    finish_up();
  end

endmodule